// File: doc/BRIEF.md
# Compare/Capture Timer

A register-mapped timer for a system bus. A counter advances on ticks produced from one of four selectable clock sources followed by a programmable divider. A single compare register raises a match flag and drives a compare output, and can either restart the count or let it run freely through its full range. A capture input, synchronised and edge-qualified, latches the running count into a capture register. The two event flags feed an interrupt line that the control word gates.

Software programs the divider and the compare value, then writes one control word that selects the source, the counting mode, the capture edge, the output behaviour and whether the count survives a stop. A single control bit returns every register to zero on the following cycle.

Top module: `cct_timer`

## Requirements
- R1: After reset every register reads zero, and `irq` and `cmp_out` are low.
- R2: Word addresses are 0 control, 1 divider, 2 compare, 3 capture, 4 count and 5 status. Divider and compare keep only their low PRE_W and CNT_W bits. Control keeps bits 15 and 10:0 and reads the others as zero. A write to the count address has no effect. `bus_rdata` is zero while `bus_rd` is low.
- R3: Control bits 3:1 pick the tick source. Code 1 is the bus clock, 2 is the bus clock divided by 4, 3 is rising edges of `ext_clk` and 4 is rising edges of `slow_clk`. Codes 0, 5, 6 and 7 give no ticks. Bit 0 starts the timer.
- R4: A divider value of P gives one counter tick per P+1 source pulses, so zero counts every source pulse. From a start, the count after K bus-clock cycles on source 1 is floor(K/(P+1)).
- R5: When control bit 8 is 0, a tick that finds the count equal to compare loads 0 and sets status bit 0. The count therefore runs 0..C with a period of C+1 ticks.
- R6: When control bit 8 is 1, the count keeps incrementing through the compare value and wraps from all-ones to 0. Status bit 0 is still set at the match.
- R7: Capture is enabled by control bit 5 and qualified by bits 7:6 (0 none, 1 rising, 2 falling, 3 both). `cap_in` passes through two synchronising flops. An accepted edge copies the count into the capture register and sets status bit 1. An input change seen with count c is stored as c+2.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when control bit 4 is set and some status bit is set.
- R10: With control bit 9 at 0, `cmp_out` toggles on every match. With bit 9 at 1, it is high for the single cycle after each match.
- R11: While stopped with control bit 10 at 0, the count and `cmp_out` clear. While stopped with bit 10 at 1, the count is held.
- R12: Writing control with bit 15 set clears all registers to zero on the next cycle, including that bit itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| cap_in | input | 1 | Capture input, asynchronous |
| ext_clk | input | 1 | External tick source, asynchronous |
| slow_clk | input | 1 | Low-rate tick source, asynchronous |
| irq | output | 1 | Interrupt request |
| cmp_out | output | 1 | Compare output |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit divider. With these sizes, wrap-around from 255 to 0 is reachable in a few hundred cycles, and every divider value 0..3 can be swept against a range of elapsed cycle counts. Restart mode is swept over compare values 0 to 4 at every elapsed count up to 12. The expected count and flag are computed as a modulus and a threshold. Capture values are predicted from the count read in the cycle the input changes plus the two-flop synchroniser delay.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int STAT_W = 2;
    localparam int STAT_MATCH = 0;
    localparam int STAT_CAP   = 1;

    // bits kept in the control word: 15 and 10:0
    localparam logic [15:0] CTRL_KEEP = 16'h87FF;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_PRESC = 3'd1,
        A_CMP   = 3'd2,
        A_CAP   = 3'd3,
        A_COUNT = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_PCLK  = 3'd1,
        SRC_PCLK4 = 3'd2,
        SRC_EXT   = 3'd3,
        SRC_SLOW  = 3'd4
    } clk_src_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic       swr;        // 15
        logic [3:0] rsvd;       // 14:11
        logic       hold;       // 10
        logic       pulse_mode; // 9
        logic       free_run;   // 8
        logic [1:0] edge_sel;   // 7:6
        logic       cap_en;     // 5
        logic       irq_en;     // 4
        logic [2:0] src;        // 3:1
        logic       en;         // 0
    } ctrl_t;

    function automatic logic edge_hit(input logic [1:0] sel,
                                      input logic rise, input logic fall);
        logic hit;
        case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge
    import cct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       hit
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    always_comb begin
        hit = edge_hit(sel, sh[STAGES-1] & ~sh[STAGES], ~sh[STAGES-1] & sh[STAGES]);
    end
endmodule

// File: rtl/cct_tick_gen.sv
module cct_tick_gen
    import cct_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic [2:0]       src,
    input  logic [PRE_W-1:0] presc,
    input  logic             ext_rise,
    input  logic             slow_rise,
    output logic             tick
);
    logic [1:0]       div_q;
    logic [PRE_W-1:0] pre_q;
    logic             src_pulse;
    logic             pre_done;

    always_comb begin
        case (src)
            SRC_PCLK:  src_pulse = 1'b1;
            SRC_PCLK4: src_pulse = (div_q == 2'd3);
            SRC_EXT:   src_pulse = ext_rise;
            SRC_SLOW:  src_pulse = slow_rise;
            default:   src_pulse = 1'b0;
        endcase
        pre_done = (pre_q >= presc);
        tick     = run & src_pulse & pre_done;
    end

    always_ff @(posedge clk) begin
        if (clr || !run) begin
            div_q <= '0;
            pre_q <= '0;
        end else begin
            div_q <= div_q + 2'd1;
            if (src_pulse) pre_q <= pre_done ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic             hold,
    input  logic             free_run,
    input  logic             pulse_mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             match,
    output logic             cmp_out
);
    always_comb match = tick & (count == cmp);

    always_ff @(posedge clk) begin
        if (clr || (!run && !hold)) begin
            count   <= '0;
            cmp_out <= 1'b0;
        end else begin
            if (tick) count <= (match && !free_run) ? '0 : count + 1'b1;
            if (pulse_mode)  cmp_out <= match;
            else if (match)  cmp_out <= ~cmp_out;
        end
    end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    input  logic              ext_clk,
    input  logic              slow_clk,
    output logic              irq,
    output logic              cmp_out
);
    localparam int N_SYNC = 3; // lanes: 0 ext, 1 slow, 2 capture

    ctrl_t             ctrl_q;
    logic [PRE_W-1:0]  presc_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cap_q;
    logic [STAT_W-1:0] status_q;
    logic [CNT_W-1:0]  count_w;
    logic              tick_w;
    logic              match_w;
    logic              clr;
    logic [N_SYNC-1:0] sync_in;
    logic [N_SYNC-1:0] sync_hit;
    logic [2*N_SYNC-1:0] sync_sel;
    logic              cap_hit;
    logic [STAT_W-1:0] stat_clr;
    logic [DATA_W-1:0] rd_word;

    assign clr = rst | ctrl_q.swr;
    assign sync_in  = {cap_in, slow_clk, ext_clk};
    assign sync_sel = {ctrl_q.edge_sel, EDGE_RISE, EDGE_RISE};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        cct_sync_edge #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (sync_in[g]),
            .sel (sync_sel[2*g +: 2]),
            .hit (sync_hit[g])
        );
    end

    cct_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk       (clk),
        .clr       (clr),
        .run       (ctrl_q.en),
        .src       (ctrl_q.src),
        .presc     (presc_q),
        .ext_rise  (sync_hit[0]),
        .slow_rise (sync_hit[1]),
        .tick      (tick_w)
    );

    cct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .clr        (clr),
        .run        (ctrl_q.en),
        .hold       (ctrl_q.hold),
        .free_run   (ctrl_q.free_run),
        .pulse_mode (ctrl_q.pulse_mode),
        .tick       (tick_w),
        .cmp        (cmp_q),
        .count      (count_w),
        .match      (match_w),
        .cmp_out    (cmp_out)
    );

    assign cap_hit  = ctrl_q.cap_en & sync_hit[2];
    assign stat_clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl_q   <= '0;
            presc_q  <= '0;
            cmp_q    <= '0;
            cap_q    <= '0;
            status_q <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL:  ctrl_q  <= ctrl_t'(bus_wdata[15:0] & CTRL_KEEP);
                    A_PRESC: presc_q <= bus_wdata[PRE_W-1:0];
                    A_CMP:   cmp_q   <= bus_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (cap_hit) cap_q <= count_w;
            status_q[STAT_MATCH] <= (status_q[STAT_MATCH] & ~stat_clr[STAT_MATCH]) | match_w;
            status_q[STAT_CAP]   <= (status_q[STAT_CAP]   & ~stat_clr[STAT_CAP])   | cap_hit;
        end
    end

    assign irq = ctrl_q.irq_en & (|status_q);

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            A_CTRL:  rd_word[15:0]        = ctrl_q;
            A_PRESC: rd_word[PRE_W-1:0]   = presc_q;
            A_CMP:   rd_word[CNT_W-1:0]   = cmp_q;
            A_CAP:   rd_word[CNT_W-1:0]   = cap_q;
            A_COUNT: rd_word[CNT_W-1:0]   = count_w;
            A_STAT:  rd_word[STAT_W-1:0]  = status_q;
            default: rd_word = '0;
        endcase
        bus_rdata = bus_rd ? rd_word : '0;
    end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp,
    input logic [15:0]      ctrl,
    input logic [1:0]       status,
    input logic             irq,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic             wclr0
);
    localparam logic [CNT_W-1:0] ONE = 1;

    // R5: a matching tick in restart mode reloads zero
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl[8] && count == cmp) |=> count == '0);

    // R5: the match flag only rises after a matching tick
    p_flag_src_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past(tick && count == cmp));

    // R6: free-running ticks step by one, wrapping at the top
    p_free_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl[8] && !ctrl[15]) |=> count == $past(count) + ONE);

    // R7: capture flag only rises while capture is enabled
    p_cap_en_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $past(ctrl[5]));

    // R8: write-one clears the match flag when no new match arrives
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd5 && wclr0 && !(tick && count == cmp)) |=> !status[0]);

    // R9: no interrupt while the enable bit is clear
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl[4] |-> !irq);

    // R11: a stopped, non-holding timer shows a zero count
    p_stop_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[0] && !ctrl[10]) |=> count == '0);

    // R12: software reset empties control, count and status next cycle
    p_swr_r12: assert property (@(posedge clk) disable iff (rst)
        ctrl[15] |=> (ctrl == 16'h0 && count == '0 && status == 2'b00));
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .count    (count_w),
    .cmp      (cmp_q),
    .ctrl     (ctrl_q),
    .status   (status_q),
    .irq      (irq),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wclr0    (bus_wdata[0])
);

// File: tb/test_cct_timer.sv
`timescale 1ns/1ps
module test_cct_timer;
    localparam int CNT_W = 8;
    localparam int PRE_W = 4;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_PRE = 3'd1, AD_CMP = 3'd2,
                           AD_CAP = 3'd3, AD_CNT = 3'd4, AD_STAT = 3'd5;
    localparam logic [31:0] EN = 32'h1, IRQE = 32'h10, CAPE = 32'h20,
                            FREE = 32'h100, PULSE = 32'h200, HOLD = 32'h400,
                            SWR = 32'h8000;
    localparam logic [31:0] S_PCLK = 32'h2, S_DIV4 = 32'h4, S_EXT = 32'h6, S_SLOW = 32'h8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_in = 1'b0, ext_clk = 1'b0, slow_clk = 1'b0;
    logic        irq, cmp_out;

    cct_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_cct_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .ext_clk(ext_clk), .slow_clk(slow_clk),
        .irq(irq), .cmp_out(cmp_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic start(input logic [31:0] p, input logic [31:0] c, input logic [31:0] cv);
        wr(AD_CTRL, 32'h0);
        wr(AD_PRE, p);
        wr(AD_CMP, c);
        wr(AD_STAT, 32'h3);
        wr(AD_CTRL, cv);
    endtask

    task automatic src_edges(input bit slow, input int n);
        for (int i = 0; i < n; i++) begin
            if (slow) slow_clk = 1'b1; else ext_clk = 1'b1;
            idle(3);
            if (slow) slow_clk = 1'b0; else ext_clk = 1'b0;
            idle(3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0, capv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 register zero", v, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 cmp_out low", {31'b0, cmp_out}, 32'h0);

        // R2: field widths, reserved bits, read strobe
        wr(AD_PRE, 32'hFFFF_FFFF); rd(AD_PRE, v); check("R2 divider width", v, 32'hF);
        wr(AD_CMP, 32'h0000_1234); rd(AD_CMP, v); check("R2 compare width", v, 32'h34);
        wr(AD_CTRL, 32'h0000_7FFE); rd(AD_CTRL, v); check("R2 control reserved", v, 32'h07FE);
        bus_addr = AD_CTRL; #0.5; check("R2 rdata idle", bus_rdata, 32'h0);
        wr(AD_CTRL, 32'h0);

        // R4 with R3 source 1: divider sweep
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 12; k += 1 + k / 3) begin
                start(32'(p), 32'hFF, EN | FREE | S_PCLK);
                idle(k);
                rd(AD_CNT, v);
                check("R4 divide by P+1", v, 32'(k / (p + 1)));
            end
        end

        // R3: bus clock divided by four
        for (int p = 0; p < 2; p++) begin
            for (int k = 3; k < 20; k += 5) begin
                start(32'(p), 32'hFF, EN | FREE | S_DIV4);
                idle(k);
                rd(AD_CNT, v);
                check("R3 div4 source", v, 32'(k / (4 * (p + 1))));
            end
        end

        // R3: external and slow sources
        start(32'h0, 32'hFF, EN | FREE | S_EXT);
        src_edges(1'b0, 5); idle(5);
        rd(AD_CNT, v); check("R3 external edges", v, 32'd5);
        start(32'h1, 32'hFF, EN | FREE | S_SLOW);
        src_edges(1'b1, 6); idle(5);
        rd(AD_CNT, v); check("R3 slow edges /2", v, 32'd3);
        start(32'h0, 32'hFF, EN | FREE | S_SLOW);
        src_edges(1'b0, 3); idle(5);
        rd(AD_CNT, v); check("R3 slow ignores ext", v, 32'd0);
        start(32'h0, 32'hFF, EN | FREE | 32'hA);
        idle(10); rd(AD_CNT, v); check("R3 code 5 no ticks", v, 32'd0);
        start(32'h0, 32'hFF, EN | FREE);
        idle(10); rd(AD_CNT, v); check("R3 code 0 no ticks", v, 32'd0);

        // R5: restart mode sweep
        for (int c = 0; c < 5; c++) begin
            for (int k = 0; k < 13; k++) begin
                start(32'h0, 32'(c), EN | S_PCLK);
                idle(k);
                rd(AD_CNT, v);
                check("R5 restart count", v, 32'(k % (c + 1)));
                rd(AD_STAT, v);
                check("R5 match flag", v & 32'h1, (k >= c + 1) ? 32'h1 : 32'h0);
            end
        end

        // R6: free running through compare and wrap
        start(32'h0, 32'h5, EN | FREE | S_PCLK);
        idle(20);
        rd(AD_CNT, v); check("R6 passes compare", v, 32'd20);
        rd(AD_STAT, v); check("R6 match flag", v & 32'h1, 32'h1);
        idle(280);
        rd(AD_CNT, v); check("R6 wrap", v, 32'd44);

        // R7: capture edges
        start(32'h0, 32'hFF, EN | FREE | S_PCLK | CAPE | 32'h40);
        idle(4);
        rd(AD_CNT, c0); cap_in = 1'b1; idle(4);
        rd(AD_CAP, v); check("R7 rising capture", v, c0 + 32'd2);
        rd(AD_STAT, v); check("R7 capture flag", v & 32'h2, 32'h2);
        wr(AD_STAT, 32'h2); rd(AD_CAP, capv);
        cap_in = 1'b0; idle(4);
        rd(AD_STAT, v); check("R7 fall ignored on rise", v & 32'h2, 32'h0);
        rd(AD_CAP, v); check("R7 capture kept", v, capv);

        start(32'h0, 32'hFF, EN | FREE | S_PCLK | CAPE | 32'h80);
        cap_in = 1'b1; idle(4);
        rd(AD_STAT, v); check("R7 rise ignored on fall", v & 32'h2, 32'h0);
        rd(AD_CNT, c0); cap_in = 1'b0; idle(4);
        rd(AD_CAP, v); check("R7 falling capture", v, c0 + 32'd2);

        start(32'h0, 32'hFF, EN | FREE | S_PCLK | CAPE | 32'hC0);
        idle(2);
        rd(AD_CNT, c0); cap_in = 1'b1; idle(5);
        rd(AD_CAP, v); check("R7 both rise", v, c0 + 32'd2);
        rd(AD_CNT, c0); cap_in = 1'b0; idle(5);
        rd(AD_CAP, v); check("R7 both fall", v, c0 + 32'd2);

        start(32'h0, 32'hFF, EN | FREE | S_PCLK | 32'hC0);
        rd(AD_CAP, capv);
        cap_in = 1'b1; idle(5); cap_in = 1'b0; idle(5);
        rd(AD_CAP, v); check("R7 disabled capture value", v, capv);
        rd(AD_STAT, v); check("R7 disabled capture flag", v & 32'h2, 32'h0);

        // R8: write-one-to-clear
        start(32'h0, 32'h2, EN | S_PCLK);
        idle(5);
        wr(AD_CTRL, HOLD);
        rd(AD_STAT, v); check("R8 flag set", v, 32'h1);
        wr(AD_STAT, 32'h0); rd(AD_STAT, v); check("R8 zero write", v, 32'h1);
        wr(AD_STAT, 32'h2); rd(AD_STAT, v); check("R8 other bit", v, 32'h1);
        wr(AD_STAT, 32'h1); rd(AD_STAT, v); check("R8 clear", v, 32'h0);

        // R9: interrupt gating
        start(32'h0, 32'h2, EN | IRQE | S_PCLK);
        idle(5);
        check("R9 irq on", {31'b0, irq}, 32'h1);
        wr(AD_CTRL, HOLD);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        rd(AD_STAT, v); check("R9 flag still set", v & 32'h1, 32'h1);
        wr(AD_CTRL, HOLD | IRQE);
        check("R9 irq unmasked", {31'b0, irq}, 32'h1);
        wr(AD_STAT, 32'h3);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R10: compare output modes
        start(32'h0, 32'h3, EN | S_PCLK);
        for (int k = 1; k <= 12; k++) begin
            idle(1);
            check("R10 toggle", {31'b0, cmp_out}, 32'((k / 4) % 2));
        end
        start(32'h0, 32'h3, EN | PULSE | S_PCLK);
        for (int k = 1; k <= 12; k++) begin
            idle(1);
            check("R10 pulse", {31'b0, cmp_out}, (k % 4 == 0) ? 32'h1 : 32'h0);
        end

        // R11 and R2: hold versus clear while stopped; count is read-only
        start(32'h0, 32'hFF, EN | FREE | S_PCLK);
        idle(5);
        wr(AD_CTRL, HOLD);
        idle(4);
        rd(AD_CNT, v); check("R11 held count", v, 32'd6);
        wr(AD_CNT, 32'h55);
        rd(AD_CNT, v); check("R2 count read-only", v, 32'd6);
        wr(AD_CTRL, 32'h0);
        idle(1);
        rd(AD_CNT, v); check("R11 cleared count", v, 32'd0);

        // R12: software reset
        start(32'h3, 32'h20, EN | FREE | IRQE | S_PCLK);
        idle(6);
        wr(AD_CTRL, SWR | EN | S_PCLK);
        idle(1);
        rd(AD_CTRL, v); check("R12 control", v, 32'h0);
        rd(AD_PRE, v);  check("R12 divider", v, 32'h0);
        rd(AD_CMP, v);  check("R12 compare", v, 32'h0);
        rd(AD_CNT, v);  check("R12 count", v, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule